// File: doc/BRIEF.md
# Network management vector accumulator

This block collects the network-management bit vector that nodes of a time-triggered bus carry at the start of the payload of their static-segment frames. The receive path hands it payload bytes one at a time, each with a byte index. At the end of the frame it also gets a verdict pulse with three flags: frame accepted, frame came from the static segment, and preamble-indicator set. When all three flags are set, the leading bytes of that frame are merged into a running accumulator by bitwise OR.

At every communication-cycle boundary the accumulated vector is copied to a host-readable register of up to twelve bytes, and the accumulator starts the next cycle empty. When the controller is halted, a cycle boundary does not update the register. The number of vector bytes comes from a host configuration input. A change to that input takes effect at the next boundary. What the vector means is left to host software.

Top module: `nm_vector_collector`

## Requirements
- R1: The published vector equals the bitwise OR of the vectors of every contributing frame that ended in the cycle just closed.
- R2: A frame contributes only when `rx_frame_ok`, `rx_frame_static` and `rx_nm_flag` are all 1 at its `rx_frame_end` pulse. Dynamic-segment frames, rejected frames and frames without the indicator leave the result unchanged.
- R3: `nm_vec` changes only at a clock with `cyc_end` high, and every cycle starts from an empty accumulator. A cycle with no contributing frame publishes all zeros.
- R4: The length is taken from `cfg_len`, and any value above 12 is treated as 12. Vector bytes at index ≥ length read as zero, and a length of 0 yields an all-zero vector.
- R5: A `cyc_end` pulse with `ctrl_halt` high leaves `nm_vec` unchanged (halt wins). The bytes gathered in that cycle are still discarded.
- R6: Vector byte i is payload byte i (`rx_byte_idx` = i) and appears at `nm_vec[8*i+7:8*i]`.
- R7: A contributing frame with fewer payload bytes than the length adds zeros for the bytes it did not deliver.
- R8: Bytes of a frame rejected at its end pulse are discarded and do not leak into a later frame.
- R9: `nm_vec` is zero after reset. The length in force during reset is sampled from `cfg_len`, and a later change of `cfg_len` applies only from the next non-halted cycle boundary.
- R10: A frame whose end pulse falls in the same clock as `cyc_end` is counted in the vector published at that boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_len | input | 4 | Requested vector length in bytes |
| rx_byte_vld | input | 1 | Payload byte strobe |
| rx_byte_idx | input | 8 | Position of the byte in the payload |
| rx_byte_data | input | 8 | Payload byte value |
| rx_frame_end | input | 1 | One-clock pulse that closes a frame |
| rx_frame_ok | input | 1 | Frame accepted (valid at `rx_frame_end`) |
| rx_frame_static | input | 1 | Frame came from the static segment |
| rx_nm_flag | input | 1 | Preamble-indicator bit of the frame |
| cyc_end | input | 1 | One-clock pulse at the communication-cycle boundary |
| ctrl_halt | input | 1 | Controller is in its halt state |
| nm_vec | output | 96 | Published vector, byte i at bits 8i+7:8i |

## Verification
The assertions take it for granted that no payload byte strobe falls in the same clock as a frame-end pulse, and that no frame still has bytes pending when a cycle boundary passes. They rely on this to prove that the accumulator only grows within a cycle and never holds bytes beyond the active length. The stimulus respects both rules by construction. Every byte is driven on its own clock, the end pulse always follows one clock after the last byte, and boundaries are issued only between frames or in the same clock as a frame's end pulse.

// File: rtl/nmv_pkg.sv
// Package: shared constants and types for the network-management vector
// accumulator. Assumes byte-wide payload lanes.
package nmv_pkg;
    localparam int BYTE_W = 8;

    // Verdict delivered with the end-of-frame pulse.
    typedef struct packed {
        logic accepted;
        logic in_static;
        logic nm_flag;
    } frame_verdict_t;
endpackage

// File: rtl/nmv_len_ctrl.sv
// Module: holds the vector length in force for the current cycle.
// It clamps the host request to MAX_BYTES and adopts it during reset and
// at each non-halted cycle boundary only. Assumes LEN_W can encode MAX_BYTES.
module nmv_len_ctrl #(
    parameter int MAX_BYTES = 12,
    parameter int LEN_W     = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LEN_W-1:0] cfg_len,
    input  logic             boundary,
    output logic [LEN_W-1:0] active_len
);
    localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(MAX_BYTES);

    logic [LEN_W-1:0] clamped;

    // Limit the request to the storage available.
    always_comb begin
        clamped = (cfg_len > LEN_MAX) ? LEN_MAX : cfg_len;
    end

    // Load the length during reset and at each committed boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_len <= clamped;
        end else if (boundary) begin
            active_len <= clamped;
        end
    end

    assert_len_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        active_len <= LEN_MAX);

    assert_len_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !boundary |=> $stable(active_len));
endmodule

// File: rtl/nmv_frame_stage.sv
// Module: per-frame staging buffer. Captures payload bytes whose index is
// below the active length, one lane per vector byte, and clears every lane
// at the end of each frame so a short or rejected frame leaves nothing
// behind. Assumes no byte strobe coincides with the end-of-frame pulse.
module nmv_frame_stage
    import nmv_pkg::*;
#(
    parameter int MAX_BYTES = 12,
    parameter int IDX_W     = 8,
    parameter int LEN_W     = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          byte_vld,
    input  logic [IDX_W-1:0]              byte_idx,
    input  logic [BYTE_W-1:0]             byte_data,
    input  logic                          frame_end,
    input  logic [LEN_W-1:0]              active_len,
    output logic [MAX_BYTES*BYTE_W-1:0]   stage_vec
);
    for (genvar lane = 0; lane < MAX_BYTES; lane++) begin : g_lane
        logic hit;

        // Lane takes a byte that matches its position and lies within the length.
        always_comb begin
            hit = byte_vld && (byte_idx == IDX_W'(lane)) &&
                  (LEN_W'(lane) < active_len);
        end

        // Capture the byte, or empty the lane when the frame closes.
        always_ff @(posedge clk) begin
            if (!rst_n || frame_end) begin
                stage_vec[lane*BYTE_W +: BYTE_W] <= '0;
            end else if (hit) begin
                stage_vec[lane*BYTE_W +: BYTE_W] <= byte_data;
            end
        end
    end

    assert_byte_not_at_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(byte_vld && frame_end));
endmodule

// File: rtl/nmv_accum.sv
// Module: running OR accumulator and published register. A frame merges
// only with a positive three-flag verdict. A cycle boundary publishes the
// merged value masked to the active length, unless the controller is halted,
// and always empties the accumulator. Assumes no frame spans a boundary.
module nmv_accum
    import nmv_pkg::*;
#(
    parameter int MAX_BYTES = 12,
    parameter int LEN_W     = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [MAX_BYTES*BYTE_W-1:0] stage_vec,
    input  logic                        frame_end,
    input  frame_verdict_t              verdict,
    input  logic                        cyc_end,
    input  logic                        halt,
    input  logic [LEN_W-1:0]            active_len,
    output logic [MAX_BYTES*BYTE_W-1:0] nm_vec
);
    localparam int VEC_W = MAX_BYTES * BYTE_W;

    logic             take;
    logic [VEC_W-1:0] acc;
    logic [VEC_W-1:0] merged;
    logic [VEC_W-1:0] len_mask;
    logic             acc_beyond;

    // Decide whether the closing frame contributes.
    always_comb begin
        take = frame_end && verdict.accepted && verdict.in_static && verdict.nm_flag;
    end

    // Fold the staged frame into the running value.
    always_comb begin
        merged = acc | (take ? stage_vec : '0);
    end

    // Build a byte mask from the length in force this cycle.
    for (genvar b = 0; b < MAX_BYTES; b++) begin : g_mask
        assign len_mask[b*BYTE_W +: BYTE_W] =
            (LEN_W'(b) < active_len) ? {BYTE_W{1'b1}} : {BYTE_W{1'b0}};
    end

    // Running accumulator: emptied at every boundary, grown by contributors.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= '0;
        end else if (cyc_end) begin
            acc <= '0;
        end else if (take) begin
            acc <= merged;
        end
    end

    // Published register: copied at a boundary unless halted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nm_vec <= '0;
        end else if (cyc_end && !halt) begin
            nm_vec <= merged & len_mask;
        end
    end

    // Flag any accumulated byte outside the active length.
    always_comb begin
        acc_beyond = 1'b0;
        for (int b = 0; b < MAX_BYTES; b++) begin
            if ((LEN_W'(b) >= active_len) && (acc[b*BYTE_W +: BYTE_W] != '0)) begin
                acc_beyond = 1'b1;
            end
        end
    end

    assert_acc_fresh_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_end |=> (acc == '0));

    assert_pub_only_boundary_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_end |=> $stable(nm_vec));

    assert_acc_grows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_end |=> ((acc & $past(acc)) == $past(acc)));

    assert_halt_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_end && halt) |=> $stable(nm_vec));

    assert_rejected_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end && !cyc_end &&
         !(verdict.accepted && verdict.in_static && verdict.nm_flag)) |=> $stable(acc));

    assert_acc_within_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_beyond);
endmodule

// File: rtl/nm_vector_collector.sv
// Module: top of the network-management vector accumulator. Wires the
// length control, per-frame staging and OR accumulator together. A cycle
// boundary commits only while the controller is not halted.
module nm_vector_collector
    import nmv_pkg::*;
#(
    parameter int MAX_BYTES = 12,
    parameter int IDX_W     = 8,
    parameter int LEN_W     = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [LEN_W-1:0]            cfg_len,
    input  logic                        rx_byte_vld,
    input  logic [IDX_W-1:0]            rx_byte_idx,
    input  logic [7:0]                  rx_byte_data,
    input  logic                        rx_frame_end,
    input  logic                        rx_frame_ok,
    input  logic                        rx_frame_static,
    input  logic                        rx_nm_flag,
    input  logic                        cyc_end,
    input  logic                        ctrl_halt,
    output logic [MAX_BYTES*8-1:0]      nm_vec
);
    localparam int VEC_W = MAX_BYTES * BYTE_W;

    logic             boundary;
    logic [LEN_W-1:0] active_len;
    logic [VEC_W-1:0] stage_vec;
    frame_verdict_t   verdict;

    // Boundary that commits the length; halt suppresses it.
    always_comb begin
        boundary = cyc_end && !ctrl_halt;
    end

    // Bundle the end-of-frame flags.
    always_comb begin
        verdict.accepted  = rx_frame_ok;
        verdict.in_static = rx_frame_static;
        verdict.nm_flag   = rx_nm_flag;
    end

    nmv_len_ctrl #(.MAX_BYTES(MAX_BYTES), .LEN_W(LEN_W)) u_len (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_len    (cfg_len),
        .boundary   (boundary),
        .active_len (active_len)
    );

    nmv_frame_stage #(.MAX_BYTES(MAX_BYTES), .IDX_W(IDX_W), .LEN_W(LEN_W)) u_stage (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_vld   (rx_byte_vld),
        .byte_idx   (rx_byte_idx),
        .byte_data  (rx_byte_data),
        .frame_end  (rx_frame_end),
        .active_len (active_len),
        .stage_vec  (stage_vec)
    );

    nmv_accum #(.MAX_BYTES(MAX_BYTES), .LEN_W(LEN_W)) u_acc (
        .clk        (clk),
        .rst_n      (rst_n),
        .stage_vec  (stage_vec),
        .frame_end  (rx_frame_end),
        .verdict    (verdict),
        .cyc_end    (cyc_end),
        .halt       (ctrl_halt),
        .active_len (active_len),
        .nm_vec     (nm_vec)
    );
endmodule

// File: tb/nm_vector_collector_bench.sv
// Bench: table-driven cycles followed by directed tests for reset, halt,
// length timing, rejected-frame leakage and boundary-coincident frames.
module nm_vector_collector_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  cfg_len = 4'd12;
    logic        rx_byte_vld = 1'b0;
    logic [7:0]  rx_byte_idx = '0;
    logic [7:0]  rx_byte_data = '0;
    logic        rx_frame_end = 1'b0;
    logic        rx_frame_ok = 1'b0;
    logic        rx_frame_static = 1'b0;
    logic        rx_nm_flag = 1'b0;
    logic        cyc_end = 1'b0;
    logic        ctrl_halt = 1'b0;
    logic [95:0] nm_vec;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    nm_vector_collector u_nm_vector_collector (
        .clk(clk), .rst_n(rst_n), .cfg_len(cfg_len),
        .rx_byte_vld(rx_byte_vld), .rx_byte_idx(rx_byte_idx),
        .rx_byte_data(rx_byte_data), .rx_frame_end(rx_frame_end),
        .rx_frame_ok(rx_frame_ok), .rx_frame_static(rx_frame_static),
        .rx_nm_flag(rx_nm_flag), .cyc_end(cyc_end), .ctrl_halt(ctrl_halt),
        .nm_vec(nm_vec)
    );

    // Table: length, frame A (data, flags {ok,static,ind}, count),
    // frame B (same), expected published vector.
    localparam int NT = 8;
    localparam logic [3:0]  T_LEN [NT] = '{4'd12, 4'd12, 4'd12, 4'd12, 4'd4, 4'd12, 4'd0, 4'd15};
    localparam logic [95:0] T_A   [NT] = '{
        96'h0C0B0A090807060504030201, {12{8'h11}}, {12{8'h11}}, {12{8'h11}},
        {12{8'hFF}}, {12{8'hAA}}, {12{8'hFF}}, 96'h0C0B0A090807060504030201};
    localparam logic [2:0]  T_AF  [NT] = '{3'b111, 3'b111, 3'b111, 3'b101, 3'b111, 3'b111, 3'b111, 3'b111};
    localparam int          T_AN  [NT] = '{12, 12, 12, 12, 12, 3, 12, 12};
    localparam logic [95:0] T_B   [NT] = '{
        96'h0, {12{8'h22}}, {12{8'h44}}, {12{8'h22}},
        96'h0, {12{8'h05}}, 96'h0, 96'h0};
    localparam logic [2:0]  T_BF  [NT] = '{3'b111, 3'b111, 3'b110, 3'b011, 3'b000, 3'b111, 3'b000, 3'b000};
    localparam int          T_BN  [NT] = '{12, 12, 12, 12, 12, 12, 1, 1};
    localparam logic [95:0] T_EXP [NT] = '{
        96'h0C0B0A090807060504030201,  // R1 R6 byte i at bits 8i+7:8i
        {12{8'h33}},                   // R1 OR of two contributors
        {12{8'h11}},                   // R2 no indicator ignored
        96'h0,                         // R2 R8 dynamic and rejected ignored
        96'h0000000000000000FFFFFFFF,  // R4 length 4
        96'h050505050505050505AFAFAF,  // R7 short frame
        96'h0,                         // R4 length 0
        96'h0C0B0A090807060504030201}; // R4 length 15 clamped to 12

    task automatic check(input string tag, input logic [95:0] exp);
        checks++;
        if (nm_vec !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, nm_vec, exp);
        end
    endtask

    task automatic send_frame(input logic [95:0] data, input int n,
                              input logic [2:0] fl, input bit with_end);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rx_byte_vld  = 1'b1;
            rx_byte_idx  = 8'(i);
            rx_byte_data = data[i*8 +: 8];
        end
        @(negedge clk);
        rx_byte_vld     = 1'b0;
        rx_frame_end    = 1'b1;
        rx_frame_ok     = fl[2];
        rx_frame_static = fl[1];
        rx_nm_flag      = fl[0];
        cyc_end         = with_end;
        @(negedge clk);
        rx_frame_end    = 1'b0;
        rx_frame_ok     = 1'b0;
        rx_frame_static = 1'b0;
        rx_nm_flag      = 1'b0;
        cyc_end         = 1'b0;
    endtask

    task automatic end_cycle(input bit h);
        @(negedge clk);
        cyc_end   = 1'b1;
        ctrl_halt = h;
        @(negedge clk);
        cyc_end   = 1'b0;
        ctrl_halt = 1'b0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 reset value", 96'h0);

        for (int k = 0; k < NT; k++) begin
            cfg_len = T_LEN[k];
            end_cycle(1'b0);
            send_frame(T_A[k], T_AN[k], T_AF[k], 1'b0);
            send_frame(T_B[k], T_BN[k], T_BF[k], 1'b0);
            end_cycle(1'b0);
            check($sformatf("R1/R2/R4/R6/R7 table row %0d", k), T_EXP[k]);
        end

        // R3: stable between boundaries, empty cycle publishes zero.
        cfg_len = 4'd12;
        end_cycle(1'b0);
        send_frame({12{8'h5A}}, 12, 3'b111, 1'b0);
        end_cycle(1'b0);
        check("R3 published", {12{8'h5A}});
        send_frame({12{8'h81}}, 12, 3'b111, 1'b0);
        repeat (3) @(negedge clk);
        check("R3 stable mid-cycle", {12{8'h5A}});
        end_cycle(1'b0);
        check("R3 next cycle fresh", {12{8'h81}});
        end_cycle(1'b0);
        check("R3 empty cycle", 96'h0);

        // R5: halt wins over the boundary; gathered bytes are dropped.
        send_frame({12{8'h3C}}, 12, 3'b111, 1'b0);
        end_cycle(1'b0);
        check("R5 before halt", {12{8'h3C}});
        send_frame({12{8'h0F}}, 12, 3'b111, 1'b0);
        end_cycle(1'b1);
        check("R5 halted boundary holds", {12{8'h3C}});
        end_cycle(1'b0);
        check("R5 halted bytes discarded", 96'h0);

        // R9: length change applies from the next boundary.
        @(negedge clk);
        cfg_len = 4'd2;
        send_frame({12{8'hFF}}, 12, 3'b111, 1'b0);
        end_cycle(1'b0);
        check("R9 old length this cycle", {12{8'hFF}});
        send_frame({12{8'hFF}}, 12, 3'b111, 1'b0);
        end_cycle(1'b0);
        check("R9 new length next cycle", 96'h00000000000000000000FFFF);

        // R8: rejected frame bytes do not leak into the following frame.
        cfg_len = 4'd12;
        end_cycle(1'b0);
        send_frame({12{8'hFF}}, 12, 3'b011, 1'b0);
        send_frame(96'h0101, 2, 3'b111, 1'b0);
        end_cycle(1'b0);
        check("R8 no leak from rejected", 96'h0101);

        // R10: frame ending with the boundary is counted there.
        send_frame({12{8'h66}}, 12, 3'b111, 1'b1);
        check("R10 coincident frame counted", {12{8'h66}});
        end_cycle(1'b0);
        check("R10 not counted twice", 96'h0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule